// File: doc/BRIEF.md
# Traffic Command Sequencer with Loops

This block walks a small program of wide command words and turns each word into a train of bus transaction requests. Each command is a read, a write or a wait. It states how many transactions to make and how many idle cycles to leave between them. The sequencer reads the word at its current index through a combinational read port. It presents a request with the command type on a valid/ready handshake and steps its index when the command is complete. Address, data and the bus channels themselves belong to the consumer of the handshake.

The index can also move in other ways. A command may close a loop that jumps back to an earlier index, either a set number of times or without end. A command may repeat itself forever. A command may be marked final, and finishing it ends the program with a one-cycle done pulse. A start pulse begins the program at index 0 at any time, including in the middle of a run.

Top module: `cmd_sequencer`

## Requirements
- R1: While reset is held and after its release, `busy`, `done` and `issue_valid` are 0 and `cmd_idx` is 0.
- R2: A `start` pulse sampled high at a clock edge sends the sequencer to index 0 on that edge, whatever it was doing, and clears any loop in progress. `busy` is 1 from that edge until the program ends.
- R3: Command type, word bits [1:0]: 00 is a read and 01 is a write. Each of these raises `issue_valid` with `issue_type` equal to the code. Code 10 (wait) and code 11 never raise `issue_valid`.
- R4: The count field, bits [17:2], sets how many transactions a command makes. A count of 0 makes none, and the command completes.
- R5: The delay field, bits [33:18], puts exactly that many idle cycles between consecutive read or write transactions, with none after the last. With ready held high, a one-command program of N≥1 transactions and delay D raises `done` 2+N+(N-1)·D edges after the start edge. With a count of 0 it is 3 edges.
- R6: A wait command spends one cycle plus D idle cycles per counted unit. A one-command wait program of N units raises `done` 2+N·(D+1) edges after the start edge.
- R7: Once raised, `issue_valid` stays high with `cmd_idx` and `issue_type` unchanged until `issue_ready` is seen, unless `start` intervenes.
- R8: When the loop-end flag, bit 36, is set, finishing that command jumps to the target index in bits [45:37]. The loop count in bits [61:46] is the total number of times the loop body runs. A count of 0 or 1 runs it once, after which execution falls through to the next index.
- R9: When the infinite-loop flag, bit 62, is set on a loop-end command, the jump back is taken every time and the program never finishes.
- R10: When the repeat-forever flag, bit 35, is set, the command starts over at the same index each time it completes. It never advances and never finishes.
- R11: When the final flag, bit 34, is set, completing that command (with no jump taken) raises `done` for exactly one cycle and drops `busy`. A command without it advances to the next index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the program at index 0 |
| cmd_idx | output | 9 | Index of the command being read |
| cmd_word | input | 63 | Command word at `cmd_idx`, valid in the same cycle |
| issue_valid | output | 1 | A transaction request is presented |
| issue_ready | input | 1 | The consumer accepts the request |
| issue_type | output | 2 | Type code of the current command |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse when the final command completes |

## Verification
The stimulus table measures the edge count from start to done for reads, writes, waits, zero counts, zero and non-zero delays, and the unused type code. A design that leaves a gap after the last transaction, or gives waits the wrong length, shows a different latency. A design that issues a bus request for a wait or for the unused code shows a non-zero handshake count. Loops are run with counts of 0, 1 and 3 and then run a second time. A loop counter that is off by one, or that carries over from the earlier run, shows up as the wrong number of reads and writes. Infinite loops, repeat-forever commands, a stalled ready and a restart in the middle of a run are checked for a missing done, a dropped request and a return to index 0.

// File: rtl/cmd_sequencer.sv
module cmd_sequencer #(
  parameter int IDX_W  = 9,
  parameter int CNT_W  = 16,
  parameter int DLY_W  = 16,
  parameter int LCNT_W = 16,
  localparam int CNT_LO  = 2,
  localparam int DLY_LO  = CNT_LO + CNT_W,
  localparam int LAST_B  = DLY_LO + DLY_W,
  localparam int FORE_B  = LAST_B + 1,
  localparam int LEND_B  = LAST_B + 2,
  localparam int TGT_LO  = LAST_B + 3,
  localparam int LCNT_LO = TGT_LO + IDX_W,
  localparam int LINF_B  = LCNT_LO + LCNT_W,
  localparam int CMD_W   = LINF_B + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic [IDX_W-1:0] cmd_idx,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [1:0]       issue_type,
  output logic             busy,
  output logic             done
);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_XFER, S_GAP, S_STEP} state_t;

  state_t              state;
  logic [CNT_W-1:0]    rem;
  logic [DLY_W-1:0]    gap;
  logic [LCNT_W-1:0]   ljumps;
  logic                lact;

  wire [1:0]        f_type = cmd_word[1:0];
  wire [CNT_W-1:0]  f_cnt  = cmd_word[DLY_LO-1:CNT_LO];
  wire [DLY_W-1:0]  f_dly  = cmd_word[LAST_B-1:DLY_LO];
  wire              f_last = cmd_word[LAST_B];
  wire              f_fore = cmd_word[FORE_B];
  wire              f_lend = cmd_word[LEND_B];
  wire [IDX_W-1:0]  f_tgt  = cmd_word[LCNT_LO-1:TGT_LO];
  wire [LCNT_W-1:0] f_lcnt = cmd_word[LINF_B-1:LCNT_LO];
  wire              f_linf = cmd_word[LINF_B];

  wire              is_bus   = ~f_type[1];
  wire              rem_zero = (rem == '0);
  wire              rem_one  = (rem == CNT_W'(1));
  wire              has_gap  = (f_dly != '0);
  wire [LCNT_W-1:0] first_jumps = (f_lcnt == '0) ? '0 : f_lcnt - LCNT_W'(1);
  wire [LCNT_W-1:0] jumps_left  = lact ? ljumps : first_jumps;
  wire              take_jump   = f_lend && (f_linf || jumps_left != '0);

  assign issue_valid = (state == S_XFER) && !rem_zero && is_bus;
  assign issue_type  = f_type;
  assign busy        = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cmd_idx <= '0;
      rem     <= '0;
      gap     <= '0;
      ljumps  <= '0;
      lact    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cmd_idx <= '0;
        lact    <= 1'b0;
        state   <= S_LOAD;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_LOAD: begin
            rem   <= f_cnt;
            state <= S_XFER;
          end
          S_XFER: begin
            if (rem_zero) begin
              state <= S_STEP;
            end else if (is_bus) begin
              if (issue_ready) begin
                rem <= rem - CNT_W'(1);
                if (rem_one) begin
                  state <= S_STEP;
                end else if (has_gap) begin
                  gap   <= f_dly;
                  state <= S_GAP;
                end
              end
            end else begin
              rem <= rem - CNT_W'(1);
              if (has_gap) begin
                gap   <= f_dly;
                state <= S_GAP;
              end else if (rem_one) begin
                state <= S_STEP;
              end
            end
          end
          S_GAP: begin
            gap <= gap - DLY_W'(1);
            if (gap == DLY_W'(1)) state <= rem_zero ? S_STEP : S_XFER;
          end
          S_STEP: begin
            if (f_fore) begin
              state <= S_LOAD;
            end else if (take_jump) begin
              cmd_idx <= f_tgt;
              lact    <= 1'b1;
              if (!f_linf) ljumps <= jumps_left - LCNT_W'(1);
              state   <= S_LOAD;
            end else begin
              if (f_lend) lact <= 1'b0;
              if (f_last) begin
                done  <= 1'b1;
                state <= S_IDLE;
              end else begin
                cmd_idx <= cmd_idx + IDX_W'(1);
                state   <= S_LOAD;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

endmodule

module cmd_sequencer_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [IDX_W-1:0] cmd_idx,
  input logic             issue_valid,
  input logic             issue_ready,
  input logic [1:0]       issue_type,
  input logic             busy,
  input logic             done
);

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && cmd_idx == '0);

  // R3
  issue_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !issue_type[1]);

  // R7
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && !issue_ready && !start |=>
      issue_valid && $stable(cmd_idx) && $stable(issue_type));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !issue_valid);

endmodule

bind cmd_sequencer cmd_sequencer_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
  .issue_valid(issue_valid), .issue_ready(issue_ready),
  .issue_type(issue_type), .busy(busy), .done(done)
);

// File: tb/cmd_sequencer_test.sv
module cmd_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 63;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         issue_ready = 1'b1;
  logic [8:0]   cmd_idx;
  logic [W-1:0] cmd_word;
  logic         issue_valid, busy, done;
  logic [1:0]   issue_type;
  logic [W-1:0] prog [0:7];

  int tests = 0, fails = 0;
  int n_rd = 0, n_wr = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmd_word = prog[cmd_idx[2:0]];

  cmd_sequencer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .cmd_word(cmd_word), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_type(issue_type), .busy(busy), .done(done)
  );

  always @(negedge clk)
    if (issue_valid && issue_ready) begin
      if (issue_type == 2'b00) n_rd++;
      else if (issue_type == 2'b01) n_wr++;
    end

  initial begin
    #(CLK_PERIOD * 150000);
    timed_out = 1;
    fails++;
    tests++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [W-1:0] mk(input int ty, input int n, input int d,
      input bit last, input bit fore, input bit lend, input int tgt,
      input int lcnt, input bit linf);
    logic [W-1:0] w;
    w = '0;
    w[1:0] = 2'(ty); w[17:2] = 16'(n); w[33:18] = 16'(d);
    w[34] = last; w[35] = fore; w[36] = lend; w[45:37] = 9'(tgt);
    w[61:46] = 16'(lcnt); w[62] = linf;
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 8; i++) prog[i] = '0;
  endtask

  task automatic kick();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    n_rd = 0; n_wr = 0;
  endtask

  task automatic run(input int maxc, output int lat, output bit got);
    kick();
    lat = 0; got = 0;
    while (lat < maxc && !got) begin
      @(posedge clk); lat++;
      @(negedge clk); got = done;
    end
  endtask

  localparam int NV = 8;
  localparam int V_TY [NV] = '{0, 1, 0, 2, 2, 0, 3, 1};
  localparam int V_N  [NV] = '{1, 4, 3, 3, 2, 0, 2, 2};
  localparam int V_D  [NV] = '{0, 0, 2, 2, 0, 5, 1, 1};
  localparam int V_L  [NV] = '{3, 6, 9, 11, 4, 3, 6, 5};
  localparam int V_RD [NV] = '{1, 0, 3, 0, 0, 0, 0, 0};
  localparam int V_WR [NV] = '{0, 4, 0, 0, 0, 0, 0, 2};

  int  lat;
  bit  got;

  initial begin
    clear_prog();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 busy in reset", busy, 0);
    check("R1 valid in reset", issue_valid, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 idx after reset", cmd_idx, 0);
    check("R1 done after reset", done, 0);

    // R4 R5 R6 R3 R12-layout vectors: one-command programs, ready high
    for (int v = 0; v < NV; v++) begin
      clear_prog();
      prog[0] = mk(V_TY[v], V_N[v], V_D[v], 1, 0, 0, 0, 0, 0);
      run(200, lat, got);
      check($sformatf("R5/R6 latency v%0d", v), lat, V_L[v]);
      check($sformatf("R3/R4 reads v%0d", v), n_rd, V_RD[v]);
      check($sformatf("R3/R4 writes v%0d", v), n_wr, V_WR[v]);
    end

    // R11 done pulse width and idle afterwards
    @(negedge clk);
    check("R11 done one cycle", done, 0);
    check("R11 busy dropped", busy, 0);

    // R11 advance to next index without final flag
    clear_prog();
    prog[0] = mk(1, 1, 0, 0, 0, 0, 0, 0, 0);
    prog[1] = mk(0, 2, 0, 1, 0, 0, 0, 0, 0);
    run(200, lat, got);
    check("R11 advance done", got, 1);
    check("R11 advance writes", n_wr, 1);
    check("R11 advance reads", n_rd, 2);

    // R8 loop counts 3, 0, 1 and rerun of count 3
    clear_prog();
    prog[0] = mk(1, 2, 0, 0, 0, 0, 0, 0, 0);
    prog[1] = mk(0, 1, 1, 0, 0, 1, 0, 3, 0);
    prog[2] = mk(2, 1, 0, 1, 0, 0, 0, 0, 0);
    run(500, lat, got);
    check("R8 loop3 done", got, 1);
    check("R8 loop3 writes", n_wr, 6);
    check("R8 loop3 reads", n_rd, 3);
    run(500, lat, got);
    check("R8 loop3 rerun writes", n_wr, 6);
    check("R8 loop3 rerun reads", n_rd, 3);
    prog[1] = mk(0, 1, 1, 0, 0, 1, 0, 0, 0);
    run(500, lat, got);
    check("R8 loop0 writes", n_wr, 2);
    check("R8 loop0 reads", n_rd, 1);
    prog[1] = mk(0, 1, 1, 0, 0, 1, 0, 1, 0);
    run(500, lat, got);
    check("R8 loop1 writes", n_wr, 2);
    check("R8 loop1 reads", n_rd, 1);

    // R9 infinite loop, then R2 restart mid-run
    prog[1] = mk(0, 1, 0, 0, 0, 1, 0, 2, 1);
    run(200, lat, got);
    check("R9 no done", got, 0);
    check("R9 still busy", busy, 1);
    tests++;
    if (n_wr < 40) begin
      fails++;
      $display("FAIL R9 writes: actual=%0d expected>=40", n_wr);
    end
    clear_prog();
    prog[0] = mk(0, 2, 0, 1, 0, 0, 0, 0, 0);
    run(200, lat, got);
    check("R2 restart latency", lat, 4);
    check("R2 restart reads", n_rd, 2);
    check("R2 restart writes", n_wr, 0);

    // R10 repeat-forever command
    clear_prog();
    prog[0] = mk(0, 1, 0, 1, 1, 0, 0, 0, 0);
    prog[1] = mk(1, 1, 0, 1, 0, 0, 0, 0, 0);
    run(120, lat, got);
    check("R10 no done", got, 0);
    check("R10 idx stays", cmd_idx, 0);
    check("R10 no advance writes", n_wr, 0);
    tests++;
    if (n_rd < 30) begin
      fails++;
      $display("FAIL R10 reads: actual=%0d expected>=30", n_rd);
    end

    // R7 stall: valid held while ready low
    clear_prog();
    prog[0] = mk(0, 2, 0, 1, 0, 0, 0, 0, 0);
    issue_ready = 1'b0;
    kick();
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 valid held", issue_valid, 1);
      check("R7 type held", issue_type, 0);
    end
    @(posedge clk); #1 issue_ready = 1'b1;
    got = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      @(negedge clk); got = done;
    end
    check("R7 stall done", got, 1);
    check("R7 stall reads", n_rd, 2);

    if (!timed_out) begin
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule